// File: doc/BRIEF.md
# Audio Port Control and Status Register Bank

This block holds the configuration and error status of a serial audio port behind a simple 32-bit register bus. It has two registers: a control word and a status word. Each register sits in its own 16-byte window. Within a window the byte offset selects how a write is applied: offset 0x0 replaces the contents, 0x4 ORs the written ones into the register, and 0x8 removes the written ones. Software can therefore change single fields without a read-modify-write.

The control word carries two lock bits and the port configuration. The lock bits are a soft reset and a clock gate. The configuration bits are run, FIFO-error interrupt enable, receive direction, sample size, LR polarity invert, bit-clock edge select and one-bit frame delay. Both lock bits come up set. While either one is set, the configuration bits cannot be written. The status word reports a busy indication and two sticky FIFO error flags. The audio datapath reports errors through single-cycle strobes. The flags drive a registered interrupt output.

Reads are combinational from the address. Writes take effect at the clock edge on which `bus_wr` is sampled high. Data moves only through register accesses, so the bus has no handshake.

Top module: `aud_port_csr`

## Requirements
- R1: After reset the control word reads 0xC000_0000: soft reset is bit 31 and clock gate is bit 30. The status word reads 0, `irq_o` is 0, every configuration output is 0, and `soft_rst_o` and `clk_gate_o` are 1.
- R2: A write to control offset 0x4 sets exactly the bits written as one and leaves every other bit unchanged.
- R3: A write to control offset 0x8 clears exactly the bits written as one and leaves every other bit unchanged.
- R4: A write to control offset 0x0 replaces bits 31, 30 and 7:0. Bits 29:8 always read 0. The control bit layout is: 0 run, 1 FIFO-error interrupt enable, 2 receive direction, 4:3 sample size, 5 LR invert, 6 falling bit-clock edge, 7 frame delay. Each field drives the output port of the same name.
- R5: While bit 31 or bit 30 of control is set before a write, that write (at any offset) changes only bits 31 and 30. All configuration bits keep their values.
- R6: Status bit 1 (underflow) and bit 2 (overflow) are set by their event strobes and stay set. They clear only when a one is written to that bit at status offset 0x8. Writes to status offsets 0x0 and 0x4 have no effect.
- R7: If an event strobe and a clear of the same flag fall in the same cycle, the flag ends up set.
- R8: `irq_o` in cycle n+1 equals control bit 1 AND (underflow OR overflow) in cycle n.
- R9: Status bit 0 (busy) reads 1 whenever control bit 0 is set or `xfer_active` is high. The reading follows in the same cycle.
- R10: Writes at offset 0xC, writes with nonzero address bits 1:0, and writes outside the two windows change nothing. Reads outside the two windows return 0. The control window starts at 0x00 and the status window at 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| fifo_under_evt | input | 1 | One-cycle FIFO underflow event from the datapath |
| fifo_over_evt | input | 1 | One-cycle FIFO overflow event from the datapath |
| xfer_active | input | 1 | Datapath is moving samples |
| irq_o | output | 1 | Registered FIFO error interrupt |
| soft_rst_o | output | 1 | Soft reset to the port |
| clk_gate_o | output | 1 | Clock gate to the port |
| run_o | output | 1 | Port run enable |
| rx_mode_o | output | 1 | 1 = receive, 0 = transmit |
| word_size_o | output | 2 | Sample size select |
| lr_invert_o | output | 1 | Invert LR clock polarity |
| bclk_fall_o | output | 1 | Launch data on falling bit-clock edge |
| frame_delay_o | output | 1 | One bit-clock delay after the frame edge |

## Verification
Every configuration field drives a port directly, and the control word is readable. A wrong control bit therefore shows on a field output and on a control read in the cycle right after the faulty edge. A wrong flag value shows at a status read in that same cycle, and on `irq_o` one cycle later. A lock that leaks, or an alias that touches neighbouring bits, shows up as a field output that changes on a write that should have left it alone. The bench keeps a reference model of the control word and both flags and checks the port outputs against it every cycle, so such a fault is caught within one cycle of the offending write.

// File: rtl/aud_csr_pkg.sv
package aud_csr_pkg;
  localparam int CSR_DW  = 32;
  localparam int N_FLAG  = 2;

  // control bit positions
  localparam int B_SRST  = 31;
  localparam int B_GATE  = 30;
  localparam int B_RUN   = 0;
  localparam int B_ERRIE = 1;
  localparam int B_RX    = 2;
  localparam int B_WS    = 3;
  localparam int B_LRINV = 5;
  localparam int B_BFALL = 6;
  localparam int B_DLY   = 7;

  // status bit positions
  localparam int S_BUSY  = 0;
  localparam int S_FLAG0 = 1;

  localparam logic [CSR_DW-1:0] CTRL_WMASK = 32'hC000_00FF;
  localparam logic [CSR_DW-1:0] LOCK_MASK  = 32'hC000_0000;
  localparam logic [CSR_DW-1:0] CTRL_RST   = 32'hC000_0000;

  typedef enum logic [1:0] {
    OP_PLAIN = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_NONE  = 2'd3
  } csr_op_e;

  function automatic logic [CSR_DW-1:0] apply_op(csr_op_e op,
                                                  logic [CSR_DW-1:0] cur,
                                                  logic [CSR_DW-1:0] wd);
    case (op)
      OP_PLAIN: return wd;
      OP_SET:   return cur | wd;
      OP_CLEAR: return cur & ~wd;
      default:  return cur;
    endcase
  endfunction
endpackage

// File: rtl/aud_csr_decode.sv
module aud_csr_decode
  import aud_csr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              ctrl_we,
  output logic              stat_clr,
  output csr_op_e           op,
  output logic              sel_ctrl,
  output logic              sel_stat
);
  localparam int REG_W = ADDR_W - 4;

  logic [REG_W-1:0] region;
  logic             aligned;

  assign region   = addr[ADDR_W-1:4];
  assign aligned  = (addr[1:0] == 2'b00);
  assign op       = csr_op_e'(addr[3:2]);
  assign sel_ctrl = (region == REG_W'(0));
  assign sel_stat = (region == REG_W'(1));

  assign ctrl_we  = wr && aligned && sel_ctrl && (op != OP_NONE);
  assign stat_clr = wr && aligned && sel_stat && (op == OP_CLEAR);
endmodule

// File: rtl/aud_csr_ctrl.sv
module aud_csr_ctrl
  import aud_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  csr_op_e           op,
  input  logic [CSR_DW-1:0] wdata,
  output logic [CSR_DW-1:0] ctrl_q
);
  logic              locked;
  logic [CSR_DW-1:0] wmask;
  logic [CSR_DW-1:0] ctrl_d;

  assign locked = ctrl_q[B_SRST] | ctrl_q[B_GATE];
  assign wmask  = locked ? LOCK_MASK : CTRL_WMASK;

  always_comb begin
    ctrl_d = ctrl_q;
    if (we)
      ctrl_d = (ctrl_q & ~wmask) | (apply_op(op, ctrl_q, wdata) & wmask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CTRL_RST;
    else        ctrl_q <= ctrl_d;
  end

  // R5: configuration bits frozen while a lock bit is set
  a_r5_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(ctrl_q[B_GATE-1:0]));

  // R2: set alias leaves every written one set
  a_r2_set_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (we && op == OP_SET && !locked) |=>
      ((ctrl_q & $past(wdata & CTRL_WMASK)) == $past(wdata & CTRL_WMASK)));

  // R3: clear alias removes every written one
  a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (we && op == OP_CLEAR && !locked) |=>
      ((ctrl_q & $past(wdata & CTRL_WMASK)) == '0));
endmodule

// File: rtl/aud_csr_flag.sv
module aud_csr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr,
  output logic flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (evt) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  // R7: an event in the same cycle as a clear leaves the flag set
  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag_q);

  // R6: flag holds until cleared
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);

  // R6: a lone clear drops the flag
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt) |=> !flag_q);
endmodule

// File: rtl/aud_port_csr.sv
module aud_port_csr
  import aud_csr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              fifo_under_evt,
  input  logic              fifo_over_evt,
  input  logic              xfer_active,
  output logic              irq_o,
  output logic              soft_rst_o,
  output logic              clk_gate_o,
  output logic              run_o,
  output logic              rx_mode_o,
  output logic [1:0]        word_size_o,
  output logic              lr_invert_o,
  output logic              bclk_fall_o,
  output logic              frame_delay_o
);
  logic              ctrl_we, stat_clr, sel_ctrl, sel_stat;
  csr_op_e           op;
  logic [CSR_DW-1:0] ctrl_q;
  logic [N_FLAG-1:0] evt_v, clr_v, flag_v;
  logic [CSR_DW-1:0] stat_w;
  logic              busy;

  aud_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr       (bus_wr),
    .addr     (bus_addr),
    .ctrl_we  (ctrl_we),
    .stat_clr (stat_clr),
    .op       (op),
    .sel_ctrl (sel_ctrl),
    .sel_stat (sel_stat)
  );

  aud_csr_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (ctrl_we),
    .op     (op),
    .wdata  (bus_wdata),
    .ctrl_q (ctrl_q)
  );

  assign evt_v = {fifo_over_evt, fifo_under_evt};

  for (genvar i = 0; i < N_FLAG; i++) begin : g_flag
    assign clr_v[i] = stat_clr & bus_wdata[S_FLAG0 + i];
    aud_csr_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt_v[i]),
      .clr    (clr_v[i]),
      .flag_q (flag_v[i])
    );
  end

  assign busy = ctrl_q[B_RUN] | xfer_active;

  always_comb begin
    stat_w = '0;
    stat_w[S_BUSY] = busy;
    stat_w[S_FLAG0 +: N_FLAG] = flag_v;
  end

  always_comb begin
    if (sel_ctrl)      bus_rdata = ctrl_q;
    else if (sel_stat) bus_rdata = stat_w;
    else               bus_rdata = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= ctrl_q[B_ERRIE] & (|flag_v);
  end

  assign soft_rst_o    = ctrl_q[B_SRST];
  assign clk_gate_o    = ctrl_q[B_GATE];
  assign run_o         = ctrl_q[B_RUN];
  assign rx_mode_o     = ctrl_q[B_RX];
  assign word_size_o   = ctrl_q[B_WS +: 2];
  assign lr_invert_o   = ctrl_q[B_LRINV];
  assign bclk_fall_o   = ctrl_q[B_BFALL];
  assign frame_delay_o = ctrl_q[B_DLY];

  // R8: enabled pending flag raises the interrupt one cycle later
  a_r8_irq_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[B_ERRIE] && (|flag_v)) |=> irq_o);

  // R8: no enabled flag, no interrupt next cycle
  a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_q[B_ERRIE] && (|flag_v)) |=> !irq_o);

  // R10: reserved-offset write leaves control untouched
  a_r10_rsvd_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_ctrl && op == OP_NONE) |=> $stable(ctrl_q));
endmodule

// File: tb/aud_port_csr_bench.sv
`timescale 1ns/1ps
module aud_port_csr_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        fifo_under_evt = 1'b0, fifo_over_evt = 1'b0, xfer_active = 1'b0;
  logic        irq_o, soft_rst_o, clk_gate_o, run_o, rx_mode_o;
  logic [1:0]  word_size_o;
  logic        lr_invert_o, bclk_fall_o, frame_delay_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit live   = 0;

  always #2.5 clk = ~clk;

  aud_port_csr u_aud_port_csr (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fifo_under_evt(fifo_under_evt), .fifo_over_evt(fifo_over_evt),
    .xfer_active(xfer_active), .irq_o(irq_o), .soft_rst_o(soft_rst_o),
    .clk_gate_o(clk_gate_o), .run_o(run_o), .rx_mode_o(rx_mode_o),
    .word_size_o(word_size_o), .lr_invert_o(lr_invert_o),
    .bclk_fall_o(bclk_fall_o), .frame_delay_o(frame_delay_o)
  );

  // behavioural reference model
  logic [31:0] m_ctrl = 32'hC000_0000;
  bit          m_uf = 0, m_ov = 0, m_irq = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 32'hC000_0000; m_uf = 0; m_ov = 0; m_irq = 0;
    end else begin
      bit clr_u, clr_o;
      clr_u = 0; clr_o = 0;
      m_irq = m_ctrl[1] && (m_uf || m_ov);
      if (bus_wr && bus_addr[1:0] == 2'b00) begin
        int region, op;
        logic [31:0] msk, nv;
        region = int'(bus_addr[7:4]);
        op     = int'(bus_addr[3:2]);
        if (region == 0 && op != 3) begin
          msk = (m_ctrl[31] || m_ctrl[30]) ? 32'hC000_0000 : 32'hC000_00FF;
          if (op == 0)      nv = bus_wdata;
          else if (op == 1) nv = m_ctrl | bus_wdata;
          else              nv = m_ctrl & ~bus_wdata;
          m_ctrl = (m_ctrl & ~msk) | (nv & msk);
        end
        if (region == 1 && op == 2) begin
          clr_u = bus_wdata[1];
          clr_o = bus_wdata[2];
        end
      end
      m_uf = fifo_under_evt || (m_uf && !clr_u);
      m_ov = fifo_over_evt  || (m_ov && !clr_o);
    end
  end

  function automatic logic [31:0] model_read(logic [7:0] a);
    if (a[7:4] == 4'd0) return m_ctrl;
    if (a[7:4] == 4'd1) return {29'd0, m_ov, m_uf, m_ctrl[0] | xfer_active};
    return 32'd0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (live && rst_n) begin
      chk("R8 irq vs model", {31'd0, irq_o}, {31'd0, m_irq});
      chk(bus_addr[7:4] == 4'd1 ? "R6 status read vs model" : "R4 read vs model",
          bus_rdata, model_read(bus_addr));
      chk("R4 field outputs vs model",
          {23'd0, soft_rst_o, clk_gate_o, frame_delay_o, bclk_fall_o, lr_invert_o,
           word_size_o, rx_mode_o, run_o},
          {23'd0, m_ctrl[31], m_ctrl[30], m_ctrl[7], m_ctrl[6], m_ctrl[5],
           m_ctrl[4:3], m_ctrl[2], m_ctrl[0]});
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string req);
    @(posedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    chk(req, bus_rdata, exp);
  endtask

  task automatic events(bit u, bit o, bit w, logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1;
    fifo_under_evt = u; fifo_over_evt = o;
    bus_wr = w; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    fifo_under_evt = 0; fifo_over_evt = 0; bus_wr = 0;
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    live = 1;
    // R1 reset state
    rd(8'h00, 32'hC000_0000, "R1 control after reset");
    rd(8'h10, 32'h0, "R1 status after reset");
    chk("R1 irq after reset", {31'd0, irq_o}, 32'd0);
    chk("R1 lock outputs", {30'd0, soft_rst_o, clk_gate_o}, 32'd3);
    // R5 locked: fields ignored
    wr(8'h00, 32'hC000_00FF);
    rd(8'h00, 32'hC000_0000, "R5 plain write while locked");
    wr(8'h04, 32'h0000_0003);
    rd(8'h00, 32'hC000_0000, "R5 set write while locked");
    wr(8'h08, 32'h8000_0000);
    rd(8'h00, 32'h4000_0000, "R3 clear soft reset");
    wr(8'h00, 32'h0000_00A5);
    rd(8'h00, 32'h0000_0000, "R5 unlock write drops fields");
    // R4 plain write
    wr(8'h00, 32'h0000_00A5);
    rd(8'h00, 32'h0000_00A5, "R4 plain write");
    chk("R4 word size output", {30'd0, word_size_o}, 32'd0);
    wr(8'h00, 32'hFFFF_FF3C);
    rd(8'h00, 32'hC000_003C, "R4 unused bits read zero");
    wr(8'h08, 32'hC000_0000);
    rd(8'h00, 32'h0000_003C, "R3 unlock via clear alias");
    // R2 / R3 aliases
    wr(8'h04, 32'h0000_0003);
    rd(8'h00, 32'h0000_003F, "R2 set alias");
    wr(8'h08, 32'h0000_0014);
    rd(8'h00, 32'h0000_002B, "R3 clear alias");
    // R9 busy
    rd(8'h10, 32'h0000_0001, "R9 busy from run");
    wr(8'h08, 32'h0000_0001);
    rd(8'h10, 32'h0000_0000, "R9 idle");
    @(posedge clk); #1 xfer_active = 1;
    rd(8'h10, 32'h0000_0001, "R9 busy from transfer");
    @(posedge clk); #1 xfer_active = 0;
    // R6 / R8 flags and irq
    events(1, 0, 0, 8'h00, 32'h0);
    rd(8'h10, 32'h0000_0002, "R6 underflow set");
    chk("R8 irq raised", {31'd0, irq_o}, 32'd1);
    wr(8'h10, 32'h0000_0000);
    wr(8'h14, 32'h0000_0000);
    rd(8'h10, 32'h0000_0002, "R6 plain/set status ignored");
    wr(8'h18, 32'h0000_0004);
    rd(8'h10, 32'h0000_0002, "R6 clear other flag only");
    wr(8'h18, 32'h0000_0002);
    rd(8'h10, 32'h0000_0000, "R6 underflow cleared");
    chk("R8 irq dropped", {31'd0, irq_o}, 32'd0);
    // R7 event beats clear
    events(1, 0, 0, 8'h00, 32'h0);
    events(1, 0, 1, 8'h18, 32'h0000_0002);
    rd(8'h10, 32'h0000_0002, "R7 event wins over clear");
    events(0, 1, 1, 8'h18, 32'h0000_0006);
    rd(8'h10, 32'h0000_0004, "R7 overflow set, underflow cleared");
    wr(8'h18, 32'h0000_0004);
    rd(8'h10, 32'h0000_0000, "R6 overflow cleared");
    // R8 disabled interrupt
    wr(8'h08, 32'h0000_0002);
    events(0, 1, 0, 8'h00, 32'h0);
    rd(8'h10, 32'h0000_0004, "R8 flag set with irq disabled");
    chk("R8 irq masked", {31'd0, irq_o}, 32'd0);
    wr(8'h04, 32'h0000_0002);
    rd(8'h00, 32'h0000_002A, "R2 enable irq");
    chk("R8 irq after enable", {31'd0, irq_o}, 32'd1);
    // R10 ignored writes
    wr(8'h0C, 32'h0000_00FF);
    rd(8'h00, 32'h0000_002A, "R10 reserved offset");
    wr(8'h01, 32'h0000_00FF);
    rd(8'h00, 32'h0000_002A, "R10 unaligned write");
    wr(8'h20, 32'h0000_00FF);
    rd(8'h00, 32'h0000_002A, "R10 unmapped write");
    rd(8'h20, 32'h0000_0000, "R10 unmapped read");
    repeat (4) @(posedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule